// File: doc/BRIEF.md
# Packed Pixel Display Memory Unpacker

This block walks a frame held in a byte-wide display memory and turns it into a stream of pixel indices in raster order. Pixels run left to right within a line and lines run top to bottom. A pixel is 1, 2 or 4 bits wide. Within each byte, pixels are packed either from the most significant field down (big-endian order) or from the least significant field up (little-endian order). Every pixel leaves the block as a 4-bit index, so a palette stage can sit directly behind it.

Each line begins at its own address, computed as the frame base plus the line number times a programmable line stride. A line can therefore carry padding at its end, and the block never fetches those padding bytes. The memory port is a plain read strobe with a fixed one-cycle latency. The pixel output is a valid/ready stream that marks the last pixel of each line and the last pixel of the frame.

A start pulse captures the whole configuration. The block then runs one frame and returns to idle. A stride too short for the packed line, a zero width or height, or an unsupported depth code aborts the start and raises an error flag.

Top module: `pix_unpack`

## Requirements
- R1: Byte offset 0 from the base holds the top-left pixel, and consecutive pixels of a line come from consecutive bytes. Line n is read starting at base + n × stride. Only the first ceil(width × bits / 8) bytes of each line are read, each exactly once per frame.
- R2: Depth code 0 selects 1 bit per pixel. With order input 0 (big-endian), pixel k of a byte (k = 0..7) is bit 7−k.
- R3: Depth code 1 selects 2 bits per pixel, four per byte. With order 0, pixel k is bits [7−2k : 6−2k]. With order 1, pixel k is bits [2k+1 : 2k].
- R4: Depth code 2 selects 4 bits per pixel, two per byte. With order 0, pixel 0 is bits [7:4] and pixel 1 is bits [3:0]. With order 1, the two are swapped.
- R5: With depth code 0 and order 1 (little-endian), pixel k of a byte is bit k.
- R6: The 4-bit pixel output is the field value zero-extended. Exactly width pixels are emitted per line, and the fields past the width in a line's last byte are never emitted.
- R7: The end-of-line flag is high with the last pixel of every line. The end-of-frame flag is high only with the last pixel of the last line. The cycle after that pixel is accepted, busy is low, and no read or pixel occurs until the next start. After reset, busy, error, read strobe and pixel valid are all low.
- R8: The configuration is sampled on the start pulse. Changes to the configuration inputs during a frame, and start pulses while busy, have no effect on that frame.
- R9: A start with depth code 3, zero width, zero height, or a stride smaller than the packed line length sets the error output. That start leaves busy low and causes no reads or pixels. A later valid start clears the error output.
- R10: While pixel valid is high and ready is low, the pixel, its flags and valid are held unchanged into the next cycle, and no data is lost or fetched twice.
- R11: With ready held high, the pixels of a frame come out on consecutive cycles with no gap. This holds across byte boundaries and across line ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that samples the configuration and starts a frame |
| cfg_bpp | input | 2 | Depth code: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = invalid |
| cfg_le | input | 1 | Pixel order inside a byte: 0 = big-endian, 1 = little-endian |
| cfg_base | input | AW | Byte address of the top-left pixel |
| cfg_lao | input | AW | Byte distance between the starts of consecutive lines |
| cfg_width | input | WW | Pixels per line |
| cfg_height | input | HW | Lines per frame |
| busy | output | 1 | High while a frame is in progress |
| cfg_err | output | 1 | High after a rejected start, until the next accepted start |
| mem_rd | output | 1 | Read strobe, one per byte fetched |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| pix_valid | output | 1 | Pixel output valid |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | 4 | Pixel index, zero-extended |
| pix_eol | output | 1 | Last pixel of a line |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
A wrong field index or shift amount inside a byte shows at once as a wrong value on the very pixel that uses it. This includes the order flip and the depth-dependent step. A read counter that drifts shows as a request outside a line's packed bytes or a repeated request, usually on the first line change, where the stride is added. A pixel counter that disagrees with the fetch side shows as a missing or extra end-of-line flag, a wrong pixel count, or a bubble in the stream within one byte of the fault. Losing the held byte under back-pressure shows within one stalled cycle as a changed output.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    localparam int PIX_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        DEPTH1 = 2'd0,
        DEPTH2 = 2'd1,
        DEPTH4 = 2'd2,
        DEPTHX = 2'd3
    } depth_e;

    typedef struct packed {
        logic [PIX_W-1:0] data;
        logic             eol;
        logic             eof;
    } pix_beat_t;

    // log2 of the field width
    function automatic logic [1:0] depth_log2(depth_e d);
        case (d)
            DEPTH2:  return 2'd1;
            DEPTH4:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // index of the last pixel within one byte
    function automatic logic [2:0] last_in_byte(logic [1:0] lg);
        case (lg)
            2'd1:    return 3'd3;
            2'd2:    return 3'd1;
            default: return 3'd7;
        endcase
    endfunction

    // select pixel number 'sub' of a byte, zero-extended
    function automatic logic [PIX_W-1:0] pick_field(logic [BYTE_W-1:0] byt,
                                                    logic [1:0] lg,
                                                    logic little,
                                                    logic [2:0] sub);
        logic [2:0]        fld;
        logic [2:0]        sh;
        logic [BYTE_W-1:0] moved;
        logic [PIX_W-1:0]  mask;
        fld   = little ? sub : (last_in_byte(lg) - sub);
        sh    = fld << lg;
        moved = byt >> sh;
        case (lg)
            2'd1:    mask = 4'b0011;
            2'd2:    mask = 4'b1111;
            default: mask = 4'b0001;
        endcase
        return moved[PIX_W-1:0] & mask;
    endfunction

endpackage

// File: rtl/pxu_cfg.sv
module pxu_cfg
    import pix_unpack_pkg::*;
#(
    parameter int AW = 16,
    parameter int WW = 10,
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    cfg_bpp,
    input  logic          cfg_le,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_lao,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    input  logic          frame_done,
    output logic          run,
    output logic          err,
    output depth_e        depth_q,
    output logic          le_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] lao_q,
    output logic [WW-1:0] width_q,
    output logic [HW-1:0] height_q,
    output logic [WW-1:0] bpl_q
);

    localparam int WP = WW + 1;
    localparam int CW = ((AW > WW) ? AW : WW) + 1;

    depth_e     depth_in;
    logic [1:0] lg_in;
    logic [WP-1:0] rounded;
    logic [WW-1:0] bpl_in;
    logic          bad_in;

    always_comb begin
        depth_in = depth_e'(cfg_bpp);
        lg_in    = depth_log2(depth_in);
        rounded  = {1'b0, cfg_width} + WP'(last_in_byte(lg_in));
        bpl_in   = WW'(rounded >> (2'd3 - lg_in));
        bad_in   = (depth_in == DEPTHX) || (cfg_width == '0) || (cfg_height == '0)
                 || (CW'(cfg_lao) < CW'(bpl_in));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            err      <= 1'b0;
            depth_q  <= DEPTH1;
            le_q     <= 1'b0;
            base_q   <= '0;
            lao_q    <= '0;
            width_q  <= '0;
            height_q <= '0;
            bpl_q    <= '0;
        end else if (start && !run) begin
            err      <= bad_in;
            run      <= !bad_in;
            depth_q  <= depth_in;
            le_q     <= cfg_le;
            base_q   <= cfg_base;
            lao_q    <= cfg_lao;
            width_q  <= cfg_width;
            height_q <= cfg_height;
            bpl_q    <= bpl_in;
        end else if (frame_done) begin
            run <= 1'b0;
        end
    end

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> !run);

    assert_run_from_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(start));

    assert_run_until_done_R7: assert property (@(posedge clk) disable iff (rst)
        run && !frame_done |=> run);

endmodule

// File: rtl/pxu_fetch.sv
module pxu_fetch
    import pix_unpack_pkg::*;
#(
    parameter int AW = 16,
    parameter int WW = 10,
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          need,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] lao_q,
    input  logic [WW-1:0] bpl_q,
    input  logic [HW-1:0] height_q,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr
);

    logic [WW-1:0] bidx;
    logic [HW-1:0] row;
    logic [AW-1:0] line_off;
    logic          all_read;
    logic          line_last;

    always_comb begin
        mem_rd    = run && !all_read && need;
        mem_addr  = base_q + line_off + AW'(bidx);
        line_last = (bidx == bpl_q - WW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bidx     <= '0;
            row      <= '0;
            line_off <= '0;
            all_read <= 1'b0;
        end else if (mem_rd) begin
            if (line_last) begin
                bidx     <= '0;
                row      <= row + HW'(1);
                line_off <= line_off + lao_q;
                if (row == height_q - HW'(1)) begin
                    all_read <= 1'b1;
                end
            end else begin
                bidx <= bidx + WW'(1);
            end
        end
    end

    assert_read_in_line_R1: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (bidx < bpl_q) && (row < height_q));

endmodule

// File: rtl/pxu_emit.sv
module pxu_emit
    import pix_unpack_pkg::*;
#(
    parameter int WW = 10,
    parameter int HW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              rd_issue,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  depth_e            depth_q,
    input  logic              le_q,
    input  logic [WW-1:0]     width_q,
    input  logic [HW-1:0]     height_q,
    input  logic              pix_ready,
    output logic              pix_valid,
    output pix_beat_t         beat,
    output logic              need,
    output logic              frame_done
);

    logic              pend;
    logic              held;
    logic [BYTE_W-1:0] byte_q;
    logic [2:0]        sub;
    logic [WW-1:0]     x;
    logic [HW-1:0]     y;

    logic [BYTE_W-1:0] cur_byte;
    logic              cur_valid;
    logic [1:0]        lg;
    logic [2:0]        sub_last;
    logic              fire;
    logic              byte_done;

    always_comb begin
        lg        = depth_log2(depth_q);
        sub_last  = last_in_byte(lg);
        cur_byte  = pend ? mem_rdata : byte_q;
        cur_valid = pend || held;
        pix_valid = run && cur_valid;
        beat.data = pick_field(cur_byte, lg, le_q, sub);
        beat.eol  = (x == width_q - WW'(1));
        beat.eof  = beat.eol && (y == height_q - HW'(1));
        fire      = pix_valid && pix_ready;
        byte_done = fire && ((sub == sub_last) || beat.eol);
        need      = !cur_valid || byte_done;
        frame_done = fire && beat.eof;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pend   <= 1'b0;
            held   <= 1'b0;
            byte_q <= '0;
            sub    <= '0;
            x      <= '0;
            y      <= '0;
        end else begin
            pend <= rd_issue;
            held <= cur_valid && !byte_done;
            if (pend) begin
                byte_q <= mem_rdata;
            end
            if (fire) begin
                if (beat.eol) begin
                    sub <= '0;
                    x   <= '0;
                    y   <= y + HW'(1);
                end else begin
                    x   <= x + WW'(1);
                    sub <= (sub == sub_last) ? 3'd0 : sub + 3'd1;
                end
            end
        end
    end

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready |=> pix_valid && $stable(beat));

    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (rst)
        pend |-> !held);

    assert_x_in_width_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> x < width_q);

    assert_eof_is_eol_R7: assert property (@(posedge clk) disable iff (rst)
        pix_valid && beat.eof |-> beat.eol);

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int AW = 16,
    parameter int WW = 10,
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    cfg_bpp,
    input  logic          cfg_le,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_lao,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    output logic          busy,
    output logic          cfg_err,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          pix_valid,
    input  logic          pix_ready,
    output logic [3:0]    pix_data,
    output logic          pix_eol,
    output logic          pix_eof
);

    logic          run;
    logic          need;
    logic          frame_done;
    depth_e        depth_q;
    logic          le_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] lao_q;
    logic [WW-1:0] width_q;
    logic [HW-1:0] height_q;
    logic [WW-1:0] bpl_q;
    pix_beat_t     beat;

    pxu_cfg #(.AW(AW), .WW(WW), .HW(HW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_bpp    (cfg_bpp),
        .cfg_le     (cfg_le),
        .cfg_base   (cfg_base),
        .cfg_lao    (cfg_lao),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .frame_done (frame_done),
        .run        (run),
        .err        (cfg_err),
        .depth_q    (depth_q),
        .le_q       (le_q),
        .base_q     (base_q),
        .lao_q      (lao_q),
        .width_q    (width_q),
        .height_q   (height_q),
        .bpl_q      (bpl_q)
    );

    pxu_fetch #(.AW(AW), .WW(WW), .HW(HW)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .need     (need),
        .base_q   (base_q),
        .lao_q    (lao_q),
        .bpl_q    (bpl_q),
        .height_q (height_q),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr)
    );

    pxu_emit #(.WW(WW), .HW(HW)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .rd_issue   (mem_rd),
        .mem_rdata  (mem_rdata),
        .depth_q    (depth_q),
        .le_q       (le_q),
        .width_q    (width_q),
        .height_q   (height_q),
        .pix_ready  (pix_ready),
        .pix_valid  (pix_valid),
        .beat       (beat),
        .need       (need),
        .frame_done (frame_done)
    );

    assign busy     = run;
    assign pix_data = beat.data;
    assign pix_eol  = beat.eol;
    assign pix_eof  = beat.eof;

endmodule

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;

    localparam int AW    = 16;
    localparam int WW    = 10;
    localparam int HW    = 10;
    localparam int MEMSZ = 1024;

    typedef struct packed {
        logic [1:0]  bpp;
        logic        le;
        logic [15:0] base;
        logic [15:0] lao;
        logic [9:0]  w;
        logic [9:0]  h;
        logic        rnd;
        logic        restart;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 16'h0010, 16'd4, 10'd13, 10'd3, 1'b0, 1'b0},
        '{2'd0, 1'b1, 16'h0040, 16'd3, 10'd24, 10'd2, 1'b1, 1'b1},
        '{2'd1, 1'b0, 16'h0080, 16'd5, 10'd10, 10'd3, 1'b1, 1'b0},
        '{2'd1, 1'b1, 16'h00C0, 16'd3, 10'd9,  10'd2, 1'b0, 1'b1},
        '{2'd2, 1'b0, 16'h0100, 16'd6, 10'd7,  10'd4, 1'b1, 1'b0},
        '{2'd2, 1'b1, 16'h0140, 16'd2, 10'd4,  10'd3, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h01F0, 16'd1, 10'd1,  10'd1, 1'b0, 1'b0},
        '{2'd2, 1'b0, 16'h0200, 16'd1, 10'd1,  10'd5, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          start;
    logic [1:0]    cfg_bpp;
    logic          cfg_le;
    logic [AW-1:0] cfg_base;
    logic [AW-1:0] cfg_lao;
    logic [WW-1:0] cfg_width;
    logic [HW-1:0] cfg_height;
    logic          busy;
    logic          cfg_err;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          pix_valid;
    logic          pix_ready;
    logic [3:0]    pix_data;
    logic          pix_eol;
    logic          pix_eof;

    pix_unpack #(.AW(AW), .WW(WW), .HW(HW)) u_pix_unpack (
        .clk(clk), .rst(rst), .start(start),
        .cfg_bpp(cfg_bpp), .cfg_le(cfg_le), .cfg_base(cfg_base), .cfg_lao(cfg_lao),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .busy(busy), .cfg_err(cfg_err),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .pix_eol(pix_eol), .pix_eof(pix_eof)
    );

    logic [7:0] mem [MEMSZ];
    bit         rd_seen [MEMSZ];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int e_bpp, e_le, e_base, e_lao, e_w, e_h, e_bpl;
    int ex_x, ex_y;
    int px_cnt, eol_cnt, rd_cnt, bad_rd, gap, any_act;
    bit seen_first, done_flag, mon_on, rnd_mode;
    bit stall_pend;
    logic [5:0] stall_val;
    logic [31:0] lfsr = 32'h1234_5679;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_pix(int x, int y);
        int ppb, a, sub, f, v;
        ppb = 8 >> e_bpp;
        a   = e_base + y * e_lao + x / ppb;
        sub = x % ppb;
        f   = (e_le != 0) ? sub : ppb - 1 - sub;
        v   = int'(mem[a]);
        return (v >> (f << e_bpp)) & ((1 << (1 << e_bpp)) - 1);
    endfunction

    function automatic string mode_req();
        if (e_bpp == 1) return "R3";
        if (e_bpp == 2) return "R4";
        if (e_le != 0)  return "R5";
        return "R2";
    endfunction

    // memory model with one-cycle latency, plus read legality tracking
    always @(posedge clk) begin
        if (mem_rd) begin
            int a, off;
            a = int'(mem_addr);
            mem_rdata <= (a < MEMSZ) ? mem[a] : 8'h00;
            rd_cnt++;
            any_act++;
            off = a - e_base;
            if (a >= MEMSZ || off < 0 || e_lao == 0) begin
                bad_rd++;
            end else begin
                if ((off / e_lao) >= e_h || (off % e_lao) >= e_bpl || rd_seen[a]) bad_rd++;
                rd_seen[a] = 1'b1;
            end
        end
    end

    // output monitor and ready driver, away from the active edge
    always @(negedge clk) begin
        bit r;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        r = rnd_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
        pix_ready = r;
        if (pix_valid) any_act++;
        if (mon_on && !done_flag) begin
            if (stall_pend) begin
                chk(pix_valid && ({pix_data, pix_eol, pix_eof} == stall_val), "R10",
                    "held pixel", int'({pix_valid, pix_data, pix_eol, pix_eof}),
                    int'({1'b1, stall_val}));
            end
            stall_pend = pix_valid && !r;
            stall_val  = {pix_data, pix_eol, pix_eof};
            if (pix_valid) seen_first = 1'b1;
            else if (seen_first) gap++;
            if (pix_valid && r) begin
                int ev;
                bit el, ef;
                ev = exp_pix(ex_x, ex_y);
                el = (ex_x == e_w - 1);
                ef = el && (ex_y == e_h - 1);
                chk(int'(pix_data) == ev, mode_req(), "pixel", int'(pix_data), ev);
                chk(pix_eol == el && pix_eof == ef, "R7", "eol/eof",
                    int'({pix_eol, pix_eof}), int'({el, ef}));
                px_cnt++;
                if (pix_eol) eol_cnt++;
                if (el) begin ex_x = 0; ex_y++; end
                else ex_x++;
                if (pix_eof || ex_y >= e_h) done_flag = 1'b1;
            end
        end
    end

    task automatic clear_frame();
        for (int i = 0; i < MEMSZ; i++) rd_seen[i] = 1'b0;
        px_cnt = 0; eol_cnt = 0; rd_cnt = 0; bad_rd = 0; gap = 0; any_act = 0;
        ex_x = 0; ex_y = 0;
        seen_first = 1'b0; done_flag = 1'b0; stall_pend = 1'b0;
    endtask

    task automatic drive_cfg(input int bpp, input int le, input int base,
                             input int lao, input int w, input int h);
        cfg_bpp    = 2'(bpp);
        cfg_le     = 1'(le);
        cfg_base   = AW'(base);
        cfg_lao    = AW'(lao);
        cfg_width  = WW'(w);
        cfg_height = HW'(h);
    endtask

    task automatic run_frame(input vec_t v);
        int t;
        int ppb;
        e_bpp = int'(v.bpp); e_le = int'(v.le); e_base = int'(v.base);
        e_lao = int'(v.lao); e_w = int'(v.w); e_h = int'(v.h);
        ppb   = 8 >> e_bpp;
        e_bpl = (e_w + ppb - 1) / ppb;
        rnd_mode = v.rnd;
        clear_frame();
        @(negedge clk);
        drive_cfg(e_bpp, e_le, e_base, e_lao, e_w, e_h);
        mon_on = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        // R8: scramble the configuration inputs once the frame is running
        drive_cfg(3 - e_bpp, 1 - e_le, e_base + 7, 1, e_w + 3, e_h + 2);
        if (v.restart) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done_flag && t < 5000) begin
            @(posedge clk);
            t++;
        end
        @(negedge clk);
        chk(busy == 1'b0, "R7", "busy after last pixel", int'(busy), 0);
        chk(cfg_err == 1'b0, "R8", "no error on accepted frame", int'(cfg_err), 0);
        chk(px_cnt == e_w * e_h, "R6", "pixel count", px_cnt, e_w * e_h);
        chk(eol_cnt == e_h, "R7", "end-of-line count", eol_cnt, e_h);
        chk(rd_cnt == e_h * e_bpl, "R1", "read count", rd_cnt, e_h * e_bpl);
        chk(bad_rd == 0, "R1", "illegal or repeated reads", bad_rd, 0);
        if (!v.rnd) chk(gap == 0, "R11", "bubbles with ready high", gap, 0);
        any_act = 0;
        repeat (4) @(negedge clk);
        chk(any_act == 0 && !busy, "R7", "idle after frame", any_act, 0);
        mon_on = 1'b0;
    endtask

    task automatic err_case(input int bpp, input int lao, input int w, input int h,
                            input string what);
        clear_frame();
        @(negedge clk);
        drive_cfg(bpp, 0, 16'h0300, lao, w, h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R9", what, int'(cfg_err), 1);
        chk(busy == 1'b0, "R9", "busy after rejected start", int'(busy), 0);
        any_act = 0;
        repeat (6) @(negedge clk);
        chk(any_act == 0, "R9", "activity after rejected start", any_act, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 3));
        rst = 1'b1; start = 1'b0; pix_ready = 1'b1;
        mon_on = 1'b0; rnd_mode = 1'b0; mem_rdata = 8'h00;
        e_base = 0; e_lao = 1; e_h = 0; e_bpl = 0;
        drive_cfg(0, 0, 0, 1, 1, 1);
        clear_frame();
        repeat (3) @(negedge clk);
        chk(!busy && !cfg_err && !mem_rd && !pix_valid, "R7", "reset state",
            int'({busy, cfg_err, mem_rd, pix_valid}), 0);
        rst = 1'b0;
        @(negedge clk);

        // vector table walked by one loop
        for (int i = 0; i < NV; i++) run_frame(VECS[i]);

        // rejected starts
        err_case(1, 2, 10, 2, "short stride");
        err_case(3, 8, 8, 2, "depth code 3");
        err_case(0, 8, 0, 2, "zero width");
        err_case(2, 8, 4, 0, "zero height");

        // an accepted start clears the error: exact-fit stride, 2 bpp big-endian
        run_frame('{2'd1, 1'b0, 16'h0280, 16'd2, 10'd8, 10'd3, 1'b1, 1'b0});
        chk(cfg_err == 1'b0, "R9", "error cleared by valid start", int'(cfg_err), 0);

        summary();
    end

endmodule